// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block settles one branch per cycle for a processor that fetches in 16-byte bundles of three instruction slots. Decode supplies the following:

- the current bundle address and the slot of the branch;
- a kind code and a form select, which chooses between a displacement target and a branch-register target;
- a 21-bit signed bundle displacement;
- the index and value of the qualifying predicate;
- a target read from a branch register;
- the destination index for a link;
- the loop-count register;
- prediction hints.

One cycle later the block reports several registered results. It gives the taken decision and the next fetch address and slot. It gives a link-register write for calls and a loop-count write for counted loops. It also raises flags for an unsupported branch and for an instruction-set switch.

Control is a two-state machine. **ST_IDLE** means no result is presented. **ST_HOLD** means a result is presented with `out_valid` high. The machine has four transitions:

- *accept*: ST_IDLE to ST_HOLD, when `in_valid` is high.
- *stream*: ST_HOLD to ST_HOLD, when `in_valid` is high again.
- *drain*: ST_HOLD to ST_IDLE, when `in_valid` is low.
- *rest*: ST_IDLE to ST_IDLE, when `in_valid` is low.

Reset forces ST_IDLE.

The kind codes are 0 conditional, 1 call, 2 return, 3 counted loop and 4 instruction-set switch. Codes 5 to 7 are unsupported. `in_indirect` = 1 selects the branch-register form.

Top module: `br_resolver`

## Requirements
- R1: In the displacement form, a taken branch goes to the bundle address plus the sign-extended `in_disp` shifted left by 4, and the low 4 bits of the result are forced to zero.
- R2: In the indirect form, a taken branch goes to `in_ind_target` with its low 4 bits cleared.
- R3: A taken branch reports slot 0. A branch that is not taken reports the next slot of the same bundle. From slot 2, it reports slot 0 of the bundle 16 bytes on.
- R4: The conditional kind (0) and the call kind (1) are taken exactly when the qualifying predicate is true. A predicate index of 0 always counts as true, whatever `in_qp_val` says.
- R5: The return kind (2) follows the predicate in the indirect form. In the displacement form it raises `out_illegal` and is not taken.
- R6: The counted-loop kind (3) in displacement form behaves according to the loop count. A nonzero count is taken, with `out_lc_we` = 1 and `out_lc_next` = count − 1. A zero count falls through with `out_lc_we` = 0. The indirect form of this kind is illegal.
- R7: A taken call sets `out_link_we`, with `out_link_data` = aligned bundle address + 16 and `out_link_idx` = `in_dst_idx`. A call that is not taken writes no link.
- R8: Kind codes 5 to 7 raise `out_illegal`, are not taken, and request no link or loop-count write. Kind 4 raises `out_isa_switch` and is not taken.
- R9: After reset `out_valid` is 0. `out_valid` goes high in the cycle after each `in_valid` cycle, and it is low after any cycle without `in_valid`.
- R10: `in_hint` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_bundle_addr | input | ADDR_W | Address of the current bundle |
| in_slot | input | 2 | Slot of the branch in its bundle |
| in_kind | input | 3 | Branch kind code |
| in_indirect | input | 1 | 1 selects the branch-register target |
| in_disp | input | DISP_W | Signed displacement in bundles |
| in_qp_idx | input | PR_W | Qualifying predicate index |
| in_qp_val | input | 1 | Qualifying predicate value |
| in_ind_target | input | ADDR_W | Branch-register read value |
| in_dst_idx | input | BR_W | Link destination register index |
| in_lc | input | LC_W | Loop-count register value |
| in_hint | input | HINT_W | Prediction hints, ignored |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Branch taken |
| out_next_addr | output | ADDR_W | Next fetch bundle address |
| out_next_slot | output | 2 | Next slot |
| out_link_we | output | 1 | Link-register write enable |
| out_link_idx | output | BR_W | Link-register index |
| out_link_data | output | ADDR_W | Link value |
| out_lc_we | output | 1 | Loop-count write enable |
| out_lc_next | output | LC_W | New loop count |
| out_illegal | output | 1 | Unsupported kind or form |
| out_isa_switch | output | 1 | Instruction-set switch seen |

## Verification
Every result is registered once, so a corrupted decision shows at the ports in the very next cycle after the branch is accepted. A stuck state in the two-state controller shows as `out_valid` missing after an accepted branch, or lingering after an idle cycle. A wrong condition source shows as a wrong `out_taken`, together with a spurious or missing link or loop-count write. A bad target or slot calculation appears directly in `out_next_addr` or `out_next_slot` for that same branch.

// File: rtl/br_res_pkg.sv
package br_res_pkg;
    typedef enum logic [2:0] {
        BK_COND  = 3'd0,
        BK_CALL  = 3'd1,
        BK_RET   = 3'd2,
        BK_CLOOP = 3'd3,
        BK_ISASW = 3'd4
    } br_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } res_state_e;

    localparam int BUNDLE_SHIFT = 4;
    localparam logic [1:0] SLOT_LAST = 2'd2;
endpackage

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] ind_target,
    output logic [ADDR_W-1:0] rel_tgt,
    output logic [ADDR_W-1:0] ind_tgt,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] seq_addr
);
    import br_res_pkg::*;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-BUNDLE_SHIFT){1'b1}}, {BUNDLE_SHIFT{1'b0}}};
    localparam logic [ADDR_W-1:0] BUNDLE_BYTES = ADDR_W'(1) << BUNDLE_SHIFT;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext  = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        base_addr = addr & ALIGN_MASK;
        rel_tgt   = (addr + (disp_ext << BUNDLE_SHIFT)) & ALIGN_MASK;
        ind_tgt   = ind_target & ALIGN_MASK;
        seq_addr  = base_addr + BUNDLE_BYTES;
    end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval #(
    parameter int PR_W = 6,
    parameter int LC_W = 64
) (
    input  logic [2:0]      kind,
    input  logic            use_ind,
    input  logic [PR_W-1:0] qp_idx,
    input  logic            qp_val,
    input  logic [LC_W-1:0] lc,
    output logic            take,
    output logic            is_call,
    output logic            lc_dec,
    output logic            illegal,
    output logic            isa_sw
);
    import br_res_pkg::*;
    logic pred_ok;

    always_comb begin
        pred_ok = (qp_idx == '0) | qp_val;
        take    = 1'b0;
        is_call = 1'b0;
        lc_dec  = 1'b0;
        illegal = 1'b0;
        isa_sw  = 1'b0;
        case (kind)
            BK_COND:  take = pred_ok;
            BK_CALL: begin
                take    = pred_ok;
                is_call = 1'b1;
            end
            BK_RET: begin
                if (use_ind) take = pred_ok;
                else         illegal = 1'b1;
            end
            BK_CLOOP: begin
                if (!use_ind) begin
                    take   = (lc != '0);
                    lc_dec = (lc != '0);
                end else begin
                    illegal = 1'b1;
                end
            end
            BK_ISASW: isa_sw = 1'b1;
            default:  illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/br_resolver.sv
module br_resolver #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 21,
    parameter int PR_W   = 6,
    parameter int BR_W   = 3,
    parameter int LC_W   = 64,
    parameter int HINT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_bundle_addr,
    input  logic [1:0]        in_slot,
    input  logic [2:0]        in_kind,
    input  logic              in_indirect,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [PR_W-1:0]   in_qp_idx,
    input  logic              in_qp_val,
    input  logic [ADDR_W-1:0] in_ind_target,
    input  logic [BR_W-1:0]   in_dst_idx,
    input  logic [LC_W-1:0]   in_lc,
    input  logic [HINT_W-1:0] in_hint,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_addr,
    output logic [1:0]        out_next_slot,
    output logic              out_link_we,
    output logic [BR_W-1:0]   out_link_idx,
    output logic [ADDR_W-1:0] out_link_data,
    output logic              out_lc_we,
    output logic [LC_W-1:0]   out_lc_next,
    output logic              out_illegal,
    output logic              out_isa_switch
);
    import br_res_pkg::*;

    logic [ADDR_W-1:0] rel_tgt, ind_tgt, base_addr, seq_addr;
    logic take, is_call, lc_dec, illegal, isa_sw;
    logic hint_unused;
    logic [ADDR_W-1:0] nxt_addr;
    logic [1:0]        nxt_slot;
    res_state_e        state_q, state_d;

    assign hint_unused = ^in_hint;

    br_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .addr(in_bundle_addr), .disp(in_disp), .ind_target(in_ind_target),
        .rel_tgt(rel_tgt), .ind_tgt(ind_tgt), .base_addr(base_addr), .seq_addr(seq_addr)
    );

    br_cond_eval #(.PR_W(PR_W), .LC_W(LC_W)) u_cond (
        .kind(in_kind), .use_ind(in_indirect), .qp_idx(in_qp_idx), .qp_val(in_qp_val),
        .lc(in_lc), .take(take), .is_call(is_call), .lc_dec(lc_dec),
        .illegal(illegal), .isa_sw(isa_sw)
    );

    always_comb begin
        if (take) begin
            nxt_addr = in_indirect ? ind_tgt : rel_tgt;
            nxt_slot = 2'd0;
        end else if (in_slot >= SLOT_LAST) begin
            nxt_addr = seq_addr;
            nxt_slot = 2'd0;
        end else begin
            nxt_addr = base_addr;
            nxt_slot = in_slot + 2'd1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_taken      <= 1'b0;
            out_next_addr  <= '0;
            out_next_slot  <= 2'd0;
            out_link_we    <= 1'b0;
            out_link_idx   <= '0;
            out_link_data  <= '0;
            out_lc_we      <= 1'b0;
            out_lc_next    <= '0;
            out_illegal    <= 1'b0;
            out_isa_switch <= 1'b0;
        end else begin
            out_taken      <= in_valid & take;
            out_link_we    <= in_valid & take & is_call;
            out_lc_we      <= in_valid & lc_dec;
            out_illegal    <= in_valid & illegal;
            out_isa_switch <= in_valid & isa_sw;
            if (in_valid) begin
                out_next_addr <= nxt_addr;
                out_next_slot <= nxt_slot;
                out_link_idx  <= in_dst_idx;
                out_link_data <= seq_addr;
                out_lc_next   <= in_lc - LC_W'(1);
            end
        end
    end
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_next_addr,
    input logic [1:0]        out_next_slot,
    input logic              out_link_we,
    input logic              out_lc_we,
    input logic              out_illegal
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_taken_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_taken) |-> (out_next_slot == 2'd0));
    assert_target_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_next_addr[3:0] == 4'd0));
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (!out_taken && !out_link_we && !out_lc_we));
    assert_link_needs_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> out_taken);
    assert_lc_needs_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_lc_we |-> out_taken);
endmodule

bind br_resolver br_resolver_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_taken(out_taken), .out_next_addr(out_next_addr), .out_next_slot(out_next_slot),
    .out_link_we(out_link_we), .out_lc_we(out_lc_we), .out_illegal(out_illegal)
);

// File: tb/br_resolver_bench.sv
module br_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_bundle_addr = '0;
    logic [1:0]  in_slot = '0;
    logic [2:0]  in_kind = '0;
    logic        in_indirect = 1'b0;
    logic [20:0] in_disp = '0;
    logic [5:0]  in_qp_idx = '0;
    logic        in_qp_val = 1'b0;
    logic [63:0] in_ind_target = '0;
    logic [2:0]  in_dst_idx = '0;
    logic [63:0] in_lc = '0;
    logic [3:0]  in_hint = '0;
    logic        out_valid, out_taken, out_link_we, out_lc_we, out_illegal, out_isa_switch;
    logic [63:0] out_next_addr, out_link_data, out_lc_next;
    logic [1:0]  out_next_slot;
    logic [2:0]  out_link_idx;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolver u_br_resolver (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic [63:0] addr, logic [1:0] slot, logic [2:0] kind, logic ind,
                         logic [20:0] disp, logic [5:0] qpi, logic qpv,
                         logic [63:0] itgt, logic [63:0] lc, logic [3:0] hint);
        @(negedge clk);
        in_bundle_addr = addr; in_slot = slot; in_kind = kind; in_indirect = ind;
        in_disp = disp; in_qp_idx = qpi; in_qp_val = qpv; in_ind_target = itgt;
        in_lc = lc; in_hint = hint; in_dst_idx = 3'd3; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 reset valid", 64'(out_valid), 64'd0);
        chk("R9 reset taken", 64'(out_taken), 64'd0);
    endtask

    task automatic t_cond_rel;
        issue(64'h1000, 2'd0, 3'd0, 1'b0, 21'd3, 6'd5, 1'b1, '0, '0, 4'd0);
        chk("R9 valid", 64'(out_valid), 64'd1);
        chk("R4 taken", 64'(out_taken), 64'd1);
        chk("R1 fwd target", out_next_addr, 64'h1030);
        chk("R3 slot0", 64'(out_next_slot), 64'd0);
        issue(64'h1000, 2'd0, 3'd0, 1'b0, 21'h1FFFFE, 6'd5, 1'b1, '0, '0, 4'd0);
        chk("R1 back target", out_next_addr, 64'h0FE0);
        issue(64'h1000, 2'd1, 3'd0, 1'b0, 21'd3, 6'd5, 1'b0, '0, '0, 4'd0);
        chk("R4 not taken", 64'(out_taken), 64'd0);
        chk("R3 same bundle", out_next_addr, 64'h1000);
        chk("R3 next slot", 64'(out_next_slot), 64'd2);
        issue(64'h1000, 2'd2, 3'd0, 1'b0, 21'd3, 6'd5, 1'b0, '0, '0, 4'd0);
        chk("R3 wrap addr", out_next_addr, 64'h1010);
        chk("R3 wrap slot", 64'(out_next_slot), 64'd0);
        issue(64'h1000, 2'd0, 3'd0, 1'b0, 21'd1, 6'd0, 1'b0, '0, '0, 4'd0);
        chk("R4 p0 always", 64'(out_taken), 64'd1);
    endtask

    task automatic t_indirect;
        issue(64'h1000, 2'd1, 3'd0, 1'b1, 21'd3, 6'd2, 1'b1, 64'h2345_678F, '0, 4'd0);
        chk("R2 taken", 64'(out_taken), 64'd1);
        chk("R2 target", out_next_addr, 64'h2345_6780);
    endtask

    task automatic t_call;
        issue(64'h4000, 2'd1, 3'd1, 1'b0, 21'd2, 6'd7, 1'b1, '0, '0, 4'd0);
        chk("R7 link we", 64'(out_link_we), 64'd1);
        chk("R7 link data", out_link_data, 64'h4010);
        chk("R7 link idx", 64'(out_link_idx), 64'd3);
        chk("R4 call target", out_next_addr, 64'h4020);
        issue(64'h4000, 2'd1, 3'd1, 1'b0, 21'd2, 6'd7, 1'b0, '0, '0, 4'd0);
        chk("R7 no link", 64'(out_link_we), 64'd0);
        chk("R4 call not taken", 64'(out_taken), 64'd0);
    endtask

    task automatic t_ret;
        issue(64'h5000, 2'd0, 3'd2, 1'b1, 21'd0, 6'd1, 1'b1, 64'h8880, '0, 4'd0);
        chk("R5 ret taken", 64'(out_taken), 64'd1);
        chk("R5 ret target", out_next_addr, 64'h8880);
        issue(64'h5000, 2'd0, 3'd2, 1'b0, 21'd4, 6'd1, 1'b1, 64'h8880, '0, 4'd0);
        chk("R5 rel illegal", 64'(out_illegal), 64'd1);
        chk("R5 rel not taken", 64'(out_taken), 64'd0);
    endtask

    task automatic t_cloop;
        issue(64'h6000, 2'd2, 3'd3, 1'b0, 21'h1FFFFF, 6'd9, 1'b0, '0, 64'd5, 4'd0);
        chk("R6 taken", 64'(out_taken), 64'd1);
        chk("R6 lc we", 64'(out_lc_we), 64'd1);
        chk("R6 lc next", out_lc_next, 64'd4);
        chk("R6 target", out_next_addr, 64'h5FF0);
        issue(64'h6000, 2'd2, 3'd3, 1'b0, 21'h1FFFFF, 6'd9, 1'b1, '0, 64'd0, 4'd0);
        chk("R6 zero falls", 64'(out_taken), 64'd0);
        chk("R6 zero no we", 64'(out_lc_we), 64'd0);
        issue(64'h6000, 2'd2, 3'd3, 1'b1, 21'd1, 6'd9, 1'b1, 64'h100, 64'd5, 4'd0);
        chk("R6 ind illegal", 64'(out_illegal), 64'd1);
        chk("R6 ind no we", 64'(out_lc_we), 64'd0);
    endtask

    task automatic t_illegal;
        for (int k = 5; k < 8; k++) begin
            issue(64'h7000, 2'd0, 3'(k), 1'b0, 21'd1, 6'd0, 1'b1, '0, 64'd3, 4'd0);
            chk("R8 illegal", 64'(out_illegal), 64'd1);
            chk("R8 not taken", 64'(out_taken), 64'd0);
            chk("R8 no writes", 64'({out_link_we, out_lc_we}), 64'd0);
        end
        issue(64'h7000, 2'd0, 3'd4, 1'b1, 21'd1, 6'd0, 1'b1, 64'h900, '0, 4'd0);
        chk("R8 isa flag", 64'(out_isa_switch), 64'd1);
        chk("R8 isa not taken", 64'(out_taken), 64'd0);
    endtask

    task automatic t_hint;
        issue(64'h1000, 2'd0, 3'd1, 1'b0, 21'd3, 6'd5, 1'b1, '0, '0, 4'hF);
        chk("R10 taken", 64'(out_taken), 64'd1);
        chk("R10 target", out_next_addr, 64'h1030);
        chk("R10 link", out_link_data, 64'h1010);
    endtask

    task automatic t_valid_drop;
        @(negedge clk);
        chk("R9 idle drop", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cond_rel();
        t_indirect();
        t_call();
        t_ret();
        t_cloop();
        t_illegal();
        t_hint();
        t_valid_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule